// File: doc/BRIEF.md
# H-Bridge Drive Control with Fault Latch

This block is the digital control core for a two-leg full bridge. It turns two direction inputs, an enable and a disable input into high-side and low-side switch commands for each leg. When the bridge must not drive, it keeps every high-side switch off. In that state a leg's low-side switch is closed only while that leg reports a negative output level, which is when current is free-wheeling through the low-side diode.

Overcurrent and overtemperature events arrive as digital flags. Either one is captured in a sticky latch that keeps the bridge off. The latch is released only by a falling edge on the disable input or a rising edge on the enable input. After a release, a restart window of a set length runs before the legs drive again. Undervoltage also turns the bridge off, but nothing is stored and normal drive resumes as soon as the condition goes away.

Every asynchronous input passes through a two-flop synchroniser. The switch commands and the active-low status flag come from registers. Each leg gets one dead cycle whenever it changes from one side to the other.

Top module: `hbridge_ctrl`

## Requirements
- R1: When the bridge is active (run_en=1, kill=0, no stored fault, no restart window, uv_lvl=0), a leg whose direction input is 1 has its high-side switch on, and a leg whose direction input is 0 has its low-side switch on. Bit 0 of hs_on and ls_on is leg A (dir_a) and bit 1 is leg B (dir_b). So dir_a=1, dir_b=0 gives hs_on=01 and ls_on=10, and the reverse gives hs_on=10 and ls_on=01.
- R2: When the bridge is active and both direction inputs are equal, both legs go to the same side: 00 gives ls_on=11 and hs_on=00, 11 gives hs_on=11 and ls_on=00. In both cases flag_n is 1.
- R3: kill=1 or run_en=0 puts the bridge in the off state: hs_on=00 and flag_n=0.
- R4: When oc_evt or ot_evt is seen high, a fault is stored. The bridge is off with flag_n=0, and it stays off after the event input returns low.
- R5: A stored fault is cleared only by a 1-to-0 change of kill or a 0-to-1 change of run_en. Changes of the direction inputs leave it in place.
- R6: When a stored fault is cleared, the bridge stays off with flag_n=0 for RESTART_CYC further cycles, and then resumes normal drive.
- R7: uv_lvl=1 puts the bridge in the off state. When uv_lvl returns to 0, drive resumes with no clearing edge needed.
- R8: In the off state, a leg's low-side switch is on exactly while that leg's negative-level input (neg_a, neg_b) is 1.
- R9: The high-side and low-side switches of one leg are never on in the same cycle. When a leg changes side, both of its switches are off for one cycle. For an input change made between clock edges, the off-going switch opens after the third rising edge and the on-going switch closes after the fourth.
- R10: While rst is held, hs_on=00, ls_on=00 and flag_n=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dir_a | input | 1 | Direction level for leg A (1 = high side) |
| dir_b | input | 1 | Direction level for leg B (1 = high side) |
| run_en | input | 1 | Enable, active high |
| kill | input | 1 | Disable, active high |
| oc_evt | input | 1 | Overcurrent event flag |
| ot_evt | input | 1 | Overtemperature event flag |
| uv_lvl | input | 1 | Supply undervoltage level |
| neg_a | input | 1 | Leg A output is below ground |
| neg_b | input | 1 | Leg B output is below ground |
| hs_on | output | 2 | High-side switch commands, bit 0 = leg A |
| ls_on | output | 2 | Low-side switch commands, bit 0 = leg A |
| flag_n | output | 1 | Status flag, low while the bridge is off |

## Verification
The drive decode is tried with all four direction combinations while the bridge is active. Forward and reverse show that each leg follows its own input, and the two equal combinations show the free-wheel states. Random mixes of enable, disable, undervoltage and negative-level inputs separate the off state from the active one and check that low-side assist follows each leg's own negative-level input. Directed fault sequences check that the latch survives the event going away and direction toggles, that it is released by each of the two clearing edges, and that the restart window holds the bridge off. A timed direction change measures the dead cycle.

// File: rtl/hb_pkg.sv
package hb_pkg;

    localparam int NLEG = 2;

    typedef struct packed {
        logic hs;
        logic ls;
    } leg_cmd_t;

    typedef enum logic [1:0] {
        LEG_OFF  = 2'b00,
        LEG_HIGH = 2'b10,
        LEG_LOW  = 2'b01
    } leg_side_e;

    // Target side for one leg from its level, the bridge-off state and the
    // reported negative output level.
    function automatic leg_cmd_t leg_target(input logic lvl,
                                            input logic off,
                                            input logic neg);
        leg_cmd_t c;
        if (off) begin
            c.hs = 1'b0;
            c.ls = neg;
        end else begin
            c.hs = lvl;
            c.ls = ~lvl;
        end
        return c;
    endfunction

endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/hb_fault_latch.sv
module hb_fault_latch #(
    parameter int RESTART_CYC = 250000
) (
    input  logic clk,
    input  logic rst,
    input  logic trip,
    input  logic kill_s,
    input  logic run_s,
    output logic latched,
    output logic recovering
);
    localparam int CW = $clog2(RESTART_CYC + 1);

    logic          kill_q, run_q;
    logic          clr_evt;
    logic [CW-1:0] cnt;

    assign clr_evt = (kill_q & ~kill_s) | (run_s & ~run_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            kill_q  <= 1'b0;
            run_q   <= 1'b0;
            latched <= 1'b0;
            cnt     <= '0;
        end else begin
            kill_q <= kill_s;
            run_q  <= run_s;
            if (trip)
                latched <= 1'b1;
            else if (clr_evt)
                latched <= 1'b0;
            if (latched && clr_evt && !trip)
                cnt <= CW'(RESTART_CYC);
            else if (cnt != '0)
                cnt <= cnt - 1'b1;
        end
    end

    assign recovering = (cnt != '0);

    a_r4_capture: assert property (@(posedge clk) disable iff (rst)
        trip |=> latched);
    a_r5_sticky: assert property (@(posedge clk) disable iff (rst)
        (latched && !clr_evt) |=> latched);
    a_r6_window_opens: assert property (@(posedge clk) disable iff (rst)
        (latched && clr_evt && !trip) |=> recovering);
endmodule

// File: rtl/hb_leg.sv
module hb_leg
    import hb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    input  logic off,
    input  logic neg,
    output logic hs,
    output logic ls
);
    leg_cmd_t want;

    always_comb want = leg_target(lvl, off, neg);

    // A switch may close only once the opposite switch is open.
    always_ff @(posedge clk) begin
        if (rst) begin
            hs <= 1'b0;
            ls <= 1'b0;
        end else begin
            hs <= want.hs & ~ls;
            ls <= want.ls & ~hs;
        end
    end

    a_r9_no_shoot: assert property (@(posedge clk) disable iff (rst)
        !(hs && ls));
    a_r9_gap_ls: assert property (@(posedge clk) disable iff (rst)
        $rose(ls) |-> !$past(hs));
    a_r9_gap_hs: assert property (@(posedge clk) disable iff (rst)
        $rose(hs) |-> !$past(ls));
endmodule

// File: rtl/hbridge_ctrl.sv
module hbridge_ctrl
    import hb_pkg::*;
#(
    parameter int RESTART_CYC = 250000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       dir_a,
    input  logic       dir_b,
    input  logic       run_en,
    input  logic       kill,
    input  logic       oc_evt,
    input  logic       ot_evt,
    input  logic       uv_lvl,
    input  logic       neg_a,
    input  logic       neg_b,
    output logic [1:0] hs_on,
    output logic [1:0] ls_on,
    output logic       flag_n
);
    localparam int SW = 2 * NLEG + 5;

    logic [SW-1:0]   raw, syn;
    logic [NLEG-1:0] lvl_s, neg_s;
    logic            run_s, kill_s, oc_s, ot_s, uv_s;
    logic            latched, recovering, off;

    assign raw = {neg_b, neg_a, uv_lvl, ot_evt, oc_evt, kill, run_en, dir_b, dir_a};

    hb_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(raw), .q(syn)
    );

    assign lvl_s  = syn[1:0];
    assign run_s  = syn[2];
    assign kill_s = syn[3];
    assign oc_s   = syn[4];
    assign ot_s   = syn[5];
    assign uv_s   = syn[6];
    assign neg_s  = syn[8:7];

    hb_fault_latch #(.RESTART_CYC(RESTART_CYC)) u_fault (
        .clk(clk), .rst(rst), .trip(oc_s | ot_s),
        .kill_s(kill_s), .run_s(run_s),
        .latched(latched), .recovering(recovering)
    );

    assign off = ~run_s | kill_s | uv_s | latched | recovering;

    for (genvar g = 0; g < NLEG; g++) begin : g_leg
        hb_leg u_leg (
            .clk(clk), .rst(rst), .lvl(lvl_s[g]), .off(off), .neg(neg_s[g]),
            .hs(hs_on[g]), .ls(ls_on[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) flag_n <= 1'b0;
        else     flag_n <= ~off;
    end

    a_r3_off_flag: assert property (@(posedge clk) disable iff (rst)
        off |=> (!flag_n && hs_on == '0));
    a_r4_latched_off: assert property (@(posedge clk) disable iff (rst)
        latched |=> !flag_n);
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        recovering |=> (hs_on == '0));
    a_r10_reset: assert property (@(posedge clk)
        rst |=> (hs_on == '0 && ls_on == '0 && !flag_n));
endmodule

// File: tb/hbridge_ctrl_test.sv
module hbridge_ctrl_test;
    localparam int RCYC = 20;

    logic       clk = 1'b0;
    logic       rst;
    logic       dir_a, dir_b, run_en, kill, oc_evt, ot_evt, uv_lvl, neg_a, neg_b;
    logic [1:0] hs_on, ls_on;
    logic       flag_n;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    hbridge_ctrl #(.RESTART_CYC(RCYC)) uut (
        .clk(clk), .rst(rst), .dir_a(dir_a), .dir_b(dir_b), .run_en(run_en),
        .kill(kill), .oc_evt(oc_evt), .ot_evt(ot_evt), .uv_lvl(uv_lvl),
        .neg_a(neg_a), .neg_b(neg_b), .hs_on(hs_on), .ls_on(ls_on), .flag_n(flag_n)
    );

    function automatic logic [1:0] exp_hs(input logic a, input logic b, input logic off);
        return off ? 2'b00 : {b, a};
    endfunction

    function automatic logic [1:0] exp_ls(input logic a, input logic b, input logic off,
                                          input logic na, input logic nb);
        return off ? {nb, na} : {~b, ~a};
    endfunction

    task automatic check(input string req, input logic [4:0] got, input logic [4:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got hs/ls/flag=%b expected %b", req, got, exp);
        end
    endtask

    task automatic settle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check_steady(input string req, input logic off);
        check(req, {hs_on, ls_on, flag_n},
              {exp_hs(dir_a, dir_b, off), exp_ls(dir_a, dir_b, off, neg_a, neg_b), ~off});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(4 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        int seed;
        seed = $urandom(32'd7341);
        rst = 1; dir_a = 0; dir_b = 0; run_en = 0; kill = 0;
        oc_evt = 0; ot_evt = 0; uv_lvl = 0; neg_a = 0; neg_b = 0;
        settle(4);
        // R10 reset state
        check("R10 reset", {hs_on, ls_on, flag_n}, 5'b00000);
        rst = 0;
        run_en = 1;
        settle(8);

        // R1 forward and reverse, R2 free-wheel pairs
        dir_a = 1; dir_b = 0; settle(8); check_steady("R1 forward", 1'b0);
        dir_a = 0; dir_b = 1; settle(8); check_steady("R1 reverse", 1'b0);
        dir_a = 0; dir_b = 0; settle(8); check_steady("R2 both low", 1'b0);
        dir_a = 1; dir_b = 1; settle(8); check_steady("R2 both high", 1'b0);

        // R9 dead cycle on leg A going high to low
        dir_a = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R9 gap cycle", {hs_on[0], ls_on[0]}, 2'b00);
        @(posedge clk);
        @(negedge clk);
        check("R9 low side closes", {hs_on[0], ls_on[0]}, 2'b01);

        // R3, R7, R8 random mixes with no faults
        for (int k = 0; k < 60; k++) begin
            logic off;
            string tag;
            dir_a  = 1'($urandom); dir_b = 1'($urandom);
            run_en = ($urandom % 4) != 0;
            kill   = ($urandom % 4) == 0;
            uv_lvl = ($urandom % 5) == 0;
            neg_a  = 1'($urandom); neg_b = 1'($urandom);
            settle(8);
            off = ~run_en | kill | uv_lvl;
            tag = uv_lvl ? "R7 undervoltage" : (off ? "R3 R8 disabled assist" : "R1 R2 random drive");
            check_steady(tag, off);
        end
        kill = 0; run_en = 1; uv_lvl = 0; neg_a = 0; neg_b = 0;
        dir_a = 1; dir_b = 0;
        settle(8);

        // R7 self recovery
        uv_lvl = 1; settle(8); check_steady("R7 uv off", 1'b1);
        uv_lvl = 0; settle(8); check_steady("R7 uv recovers", 1'b0);

        // R4 overcurrent stored
        oc_evt = 1; settle(3); oc_evt = 0; settle(10);
        check_steady("R4 oc stored", 1'b1);
        // R5 direction toggles do not clear
        dir_a = 0; dir_b = 1; settle(6); dir_a = 1; dir_b = 1; settle(8);
        check_steady("R5 toggles ignored", 1'b1);
        // R5 clear by disable falling edge, R6 restart window
        kill = 1; settle(8); check_steady("R5 still stored with kill", 1'b1);
        kill = 0; settle(10);
        check_steady("R6 restart window", 1'b1);
        settle(30);
        check_steady("R5 R6 cleared by kill fall", 1'b0);

        // R4 overtemperature stored, R5 cleared by enable rising edge
        neg_b = 1;
        ot_evt = 1; settle(3); ot_evt = 0; settle(10);
        check_steady("R4 R8 ot stored with assist", 1'b1);
        run_en = 0; settle(8); run_en = 1; settle(10);
        check_steady("R6 restart after en rise", 1'b1);
        settle(30);
        check_steady("R5 cleared by en rise", 1'b0);
        finish_run();
    end
endmodule